// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Dual DAC Register Interface

This block is the digital front end for two 12-bit converter channels that are written over an 8-bit bus. Each channel keeps a staging word and a live word. The staging word is built from two bus writes: one carries the low eight bits and the other carries the top four bits. The live word alone drives that channel's output code. A separate active-low load strobe copies both staging words into both live words at the same moment, so the two channels always change together.

The bus pins (select, write strobe, address, data) and the load strobe are asynchronous to the system clock. They pass through a multi-stage synchronizer. A write is applied level-wise for as long as select and write are both seen low, so the staging register holds whatever was on the bus when the strobe ended. The live words take their value when the synchronized load request goes from low back to high. When the optional command decode is enabled, a write to a fifth address acts like a load pulse. This lets a processor update both outputs with one more bus write instead of a dedicated load line.

Top module: `dual_dac_loader`

## Requirements
- R1: While reset is asserted and after it is released, both output codes are zero until the first load.
- R2: A write to address 3'b000 stores bus bits 7..0 as channel A staging bits 7..0. A write to 3'b010 does the same for channel B.
- R3: A write to address 3'b001 (channel A) or 3'b011 (channel B) stores bus bits 3..0 as staging bits 11..8. Bus bits 7..4 are ignored on such a write.
- R4: The two parts of a staging word may be written in either order, and the word that is later loaded is the same.
- R5: Writes to staging registers while ld_n is high, with no load command, leave both output codes unchanged.
- R6: A low pulse on ld_n, with select and write high, updates both output codes together. The update appears on the third rising clock edge after ld_n returns high at the port and not on the second (two synchronizer stages).
- R7: While the load request stays low, the output codes do not change. They take their new value only after the request returns high.
- R8: If a write overlaps a load pulse and ld_n stays low past the end of the write, the outputs receive the completed staging data.
- R9: With CMD_LOAD_EN=1, a write to any address with bit 2 set leaves both staging words alone. When that write ends, both output codes are updated as if ld_n had pulsed.
- R10: The write strobe low with select high, or select low with write strobe high, changes no staging register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select, asynchronous |
| wstb_n | input | 1 | Active-low write strobe, asynchronous |
| addr | input | 3 | Bit 2: load command; bit 1: channel; bit 0: high part |
| bus | input | 8 | Right-justified write data |
| ld_n | input | 1 | Active-low load strobe, asynchronous |
| code_a | output | 12 | Channel A live output code |
| code_b | output | 12 | Channel B live output code |

## Verification
The hardest case to reach is a load that overlaps a write. The bench must hold the load request low, run a complete byte write inside that window, and only then release the load. It must also confirm that the outputs stayed frozen the whole time and then picked up the completed word. The edge-exact timing of the update is the other delicate point. The bench releases ld_n on a falling clock edge and then counts rising edges. It samples the outputs after the second edge (expecting the old value) and after the third (expecting the new value). The command-address path is reached by writing staging data first and then issuing a write to address 3'b100 whose data byte would be visible if it leaked into a staging register.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    // Number of converter channels served by the interface
    localparam int NCH = 2;

    // Decoded target of one synchronized bus cycle
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LO   = 2'd1,
        TGT_HI   = 2'd2,
        TGT_CMD  = 2'd3
    } tgt_e;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q.pipe[g] <= RST_VAL;
                else        s_q.pipe[g] <= s_d.pipe[g];
            end
        end
    endgenerate

    assign dout = s_q.pipe[STAGES-1];

endmodule

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
#(
    parameter bit CMD_LOAD_EN = 1'b1
) (
    input  logic           sel_n,
    input  logic           wstb_n,
    input  logic [2:0]     addr,
    output logic [NCH-1:0] wr_lo,
    output logic [NCH-1:0] wr_hi,
    output logic           cmd_hit
);

    tgt_e tgt;
    logic active;

    always_comb begin
        active = !sel_n && !wstb_n;
        tgt    = TGT_NONE;
        if (active) begin
            if (addr[2]) tgt = CMD_LOAD_EN ? TGT_CMD : TGT_NONE;
            else         tgt = addr[0] ? TGT_HI : TGT_LO;
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign wr_lo[c] = (tgt == TGT_LO) && (addr[1] == c[0]);
            assign wr_hi[c] = (tgt == TGT_HI) && (addr[1] == c[0]);
        end
    endgenerate

    assign cmd_hit = (tgt == TGT_CMD);

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] bus,
    input  logic              load,
    output logic [CODE_W-1:0] stage_word,
    output logic [CODE_W-1:0] live_code
);

    localparam int HI_W = CODE_W - DATA_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [DATA_W-1:0] lo;
        logic [CODE_W-1:0] live;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_lo) c_d.lo = bus;
        if (wr_hi) c_d.hi = bus[HI_W-1:0];
        if (load)  c_d.live = {c_q.hi, c_q.lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign stage_word = {c_q.hi, c_q.lo};
    assign live_code  = c_q.live;

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacif_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CODE_W      = 12,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit CMD_LOAD_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wstb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus,
    input  logic              ld_n,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);

    localparam int SYNC_W = 3 + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_IDLE = {3'b111, {(ADDR_W + DATA_W){1'b0}}};

    logic [SYNC_W-1:0] raw, synced;
    logic              s_sel_n, s_wstb_n, s_ld_n;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_bus;

    assign raw = {sel_n, wstb_n, ld_n, addr, bus};

    dacif_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw),
        .dout  (synced)
    );

    assign {s_sel_n, s_wstb_n, s_ld_n, s_addr, s_bus} = synced;

    logic [NCH-1:0] wr_lo, wr_hi;
    logic           cmd_hit;

    dacif_decode #(
        .CMD_LOAD_EN (CMD_LOAD_EN)
    ) u_dec (
        .sel_n   (s_sel_n),
        .wstb_n  (s_wstb_n),
        .addr    (s_addr[2:0]),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .cmd_hit (cmd_hit)
    );

    // Load request: external strobe low or command write in progress
    typedef struct packed {
        logic req_low;
    } ldst_t;

    ldst_t l_d, l_q;
    logic  req_low_now;
    logic  load_rise;

    always_comb begin
        req_low_now = !s_ld_n || cmd_hit;
        load_rise   = l_q.req_low && !req_low_now;
        l_d         = l_q;
        l_d.req_low = req_low_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    logic [NCH-1:0][CODE_W-1:0] stage_word;
    logic [NCH-1:0][CODE_W-1:0] live_code;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            dacif_chan #(
                .DATA_W (DATA_W),
                .CODE_W (CODE_W)
            ) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_lo      (wr_lo[c]),
                .wr_hi      (wr_hi[c]),
                .bus        (s_bus),
                .load       (load_rise),
                .stage_word (stage_word[c]),
                .live_code  (live_code[c])
            );
        end
    endgenerate

    assign code_a = live_code[0];
    assign code_b = live_code[1];

endmodule

// File: rtl/dacif_chk.sv
module dacif_chk
    import dacif_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [CODE_W-1:0]          code_a,
    input logic [CODE_W-1:0]          code_b,
    input logic [NCH-1:0][CODE_W-1:0] stage_word,
    input logic [NCH-1:0]             wr_lo,
    input logic [NCH-1:0]             wr_hi,
    input logic                       cmd_hit,
    input logic                       load_rise
);

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (code_a == '0 && code_b == '0));

    // R5
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a != $past(code_a)) |-> $past(load_rise));

    // R7
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_b != $past(code_b)) |-> $past(load_rise));

    // R6
    joint_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_rise) |-> (code_a == $past(stage_word[0]) &&
                              code_b == $past(stage_word[1])));

    // R10
    stage_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_word[0] != $past(stage_word[0])) |-> $past(wr_lo[0] || wr_hi[0]));

    // R2
    stage_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_word[1] != $past(stage_word[1])) |-> $past(wr_lo[1] || wr_hi[1]));

    // R9
    cmd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_hit) |-> $stable(stage_word));

endmodule

bind dual_dac_loader dacif_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_a     (code_a),
    .code_b     (code_b),
    .stage_word (stage_word),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .cmd_hit    (cmd_hit),
    .load_rise  (load_rise)
);

// File: tb/test_dual_dac_loader.sv
module test_dual_dac_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        wstb_n = 1'b1;
    logic [2:0]  addr = 3'b000;
    logic [7:0]  bus = 8'h00;
    logic        ld_n = 1'b1;
    logic [11:0] code_a, code_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_dac_loader i_dual_dac_loader (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .wstb_n (wstb_n),
        .addr   (addr),
        .bus    (bus),
        .ld_n   (ld_n),
        .code_a (code_a),
        .code_b (code_b)
    );

    task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%03h expected 0x%03h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; bus = d; sel_n = 1'b0; wstb_n = 1'b0;
        repeat (3) @(negedge clk);
        wstb_n = 1'b1; sel_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_pulse();
        @(negedge clk);
        ld_n = 1'b0;
        repeat (3) @(negedge clk);
        ld_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset A", code_a, 12'h000);
        check("R1 reset B", code_b, 12'h000);
    endtask

    task automatic t_basic();
        bus_write(3'b000, 8'h34);
        bus_write(3'b001, 8'hF2);      // upper nibble of bus ignored (R3)
        bus_write(3'b011, 8'h0A);      // high first for B (R4)
        bus_write(3'b010, 8'hBC);
        check("R5 no change before load A", code_a, 12'h000);
        check("R5 no change before load B", code_b, 12'h000);
        load_pulse();
        check("R2 R3 load A", code_a, 12'h234);
        check("R4 R6 load B", code_b, 12'hABC);
    endtask

    task automatic t_timing();
        bus_write(3'b000, 8'h55);
        @(negedge clk);
        ld_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 held while low", code_a, 12'h234);
        ld_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 not yet after 2 edges", code_a, 12'h234);
        @(negedge clk);
        check("R6 updated after 3 edges", code_a, 12'h255);
        check("R6 B unchanged value", code_b, 12'hABC);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_overlap();
        @(negedge clk);
        ld_n = 1'b0;
        bus_write(3'b000, 8'h99);
        bus_write(3'b011, 8'h03);
        check("R7 frozen during overlap A", code_a, 12'h255);
        check("R7 frozen during overlap B", code_b, 12'hABC);
        ld_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 completed data A", code_a, 12'h299);
        check("R8 completed data B", code_b, 12'h3BC);
    endtask

    task automatic t_ignore();
        @(negedge clk);
        addr = 3'b000; bus = 8'hFF; sel_n = 1'b1; wstb_n = 1'b0;
        repeat (4) @(negedge clk);
        wstb_n = 1'b1;
        @(negedge clk);
        addr = 3'b010; sel_n = 1'b0;
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        repeat (4) @(negedge clk);
        load_pulse();
        check("R10 write w/o select A", code_a, 12'h299);
        check("R10 select w/o write B", code_b, 12'h3BC);
    endtask

    task automatic t_cmd();
        bus_write(3'b010, 8'h11);
        check("R5 staged only B", code_b, 12'h3BC);
        bus_write(3'b100, 8'h77);
        check("R9 cmd load B", code_b, 12'h311);
        check("R9 cmd leaves A stage", code_a, 12'h299);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_timing();
        t_overlap();
        t_ignore();
        t_cmd();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule